// File: doc/BRIEF.md
# Dual-Mode Host Bus Port

This block is the slave side of a parallel host processor port. One set of pins serves two bus styles, and a static strap input picks between them. In the first style an access is framed by chip select and a data strobe, and a level on the direction pin says whether it is a read or a write. In the second style chip select qualifies two separate active-low strobes, one for read and one for write. The port decodes a 14-bit address and a 16-bit data bus. It turns each host access into a single-cycle internal register read or write strobe, and it drives a completion handshake whose active level depends on the chosen style.

The bus control inputs cross into the internal clock through two flip-flops each. An access starts on the synchronized asserting edge, and the port stays busy until chip select or the strobe is released. The data drivers and the handshake pin are controlled through separate output-enable signals, so the pad ring can build the tri-state drivers. After reset a lockout counter, sized from the clock frequency and a settling time in microseconds, holds off all host accesses.

Top module: `dual_bus_host_port`

## Requirements
- R1: With `bus_style` high (strobe-and-direction style), an access begins when `cs_n` and `ds_rd_n` are both low. `rw_wr` high means a read and low means a write.
- R2: With `bus_style` low (split-strobe style), `ds_rd_n` low with `cs_n` low is a read, and `rw_wr` low with `cs_n` low is a write. If both strobes are low, the access is a read and no write occurs.
- R3: Each asserting edge of a qualified write gives exactly one `reg_wr` pulse, one cycle long. During that pulse `reg_addr` carries the host address and `reg_wdata` carries the host data.
- R4: A read gives one `reg_rd` pulse. The value on `reg_rdata` in that cycle appears on `data_out` with `data_oe` high until the access ends. `data_oe` is never high during a write, and `reg_wr` and `reg_rd` are never high together.
- R5: In the strobe-and-direction style, `ack_out` rests high. During an access `ack_oe` is high, and `ack_out` drives high in the strobe cycle and then low (low means done).
- R6: In the split-strobe style, `ack_out` rests low. During an access it drives low in the strobe cycle and then high, so the rising edge marks completion.
- R7: Counted from the clock edge that first sees the new input level, `ack_oe` rises on the third rising edge after a strobe asserts. The done level and the read data follow on the fourth edge. `ack_oe` and `data_oe` fall on the third edge after release.
- R8: For `CLK_HZ*LOCK_US/1e6` cycles after `rst_n` rises, no access is accepted: no `reg_wr` or `reg_rd`, and `ack_oe` stays low.
- R9: A strobe that is already asserted when the lockout ends starts no access. The host must release it and assert it again.
- R10: While reset is low and just after it rises, `ack_oe`, `data_oe`, `reg_wr` and `reg_rd` are low.
- R11: With `cs_n` high, strobe activity causes no register strobe and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_style | input | 1 | 1 = strobe-and-direction style, 0 = split-strobe style |
| cs_n | input | 1 | Chip select, active low |
| ds_rd_n | input | 1 | Data strobe (style 1) or read strobe (style 0), active low |
| rw_wr | input | 1 | Direction, 1 = read (style 1), or write strobe, active low (style 0) |
| addr | input | 14 | Host address |
| data_in | input | 16 | Host write data |
| data_out | output | 16 | Read data toward the host |
| data_oe | output | 1 | Data bus driver enable |
| ack_out | output | 1 | Handshake level (resting level when not enabled) |
| ack_oe | output | 1 | Handshake driver enable |
| reg_addr | output | 14 | Internal register address |
| reg_wdata | output | 16 | Internal write data |
| reg_wr | output | 1 | Internal write strobe, one cycle |
| reg_rd | output | 1 | Internal read strobe, one cycle |
| reg_rdata | input | 16 | Internal read data, sampled during `reg_rd` |

## Verification
Each result has a fixed latency from the clock edge that first sees a new pin level. Two synchronizer stages and one edge-detect register put `ack_oe` and the internal strobe three edges after a strobe asserts. The done level and read data come one edge later, and release shows three edges after deassertion. The bench changes the pins on the falling edge and counts rising edges before it samples at the next falling edge. It also checks that `ack_oe` is still low one edge before it is due. The number of write strobes and their address and data are taken from a monitor and compared after each access.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_STROBE = 2'd1,
    PH_ACK    = 2'd2
  } phase_t;

  typedef struct packed {
    logic act;
    logic rd;
  } bus_req_t;

  // Settling time in clock cycles, rounded up.
  function automatic int unsigned lock_cycles(input longint unsigned clk_hz,
                                              input int unsigned us);
    longint unsigned prod;
    prod = clk_hz * longint'(us);
    return int'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

  // Meaning of the three shared control pins in each bus style.
  function automatic bus_req_t bus_decode(input logic style_strobe_dir,
                                          input logic cs_n,
                                          input logic strb_n,
                                          input logic rw_wr);
    bus_req_t r;
    if (style_strobe_dir) begin
      r.act = !cs_n && !strb_n;
      r.rd  = rw_wr;
    end else begin
      r.act = !cs_n && (!strb_n || !rw_wr);
      r.rd  = !strb_n;
    end
    return r;
  endfunction

  // Level of the handshake pin for a given style and phase.
  function automatic logic ack_level(input logic style_strobe_dir,
                                     input phase_t ph);
    return (ph == PH_ACK) ? !style_strobe_dir : style_strobe_dir;
  endfunction

endpackage

// File: rtl/hpb_sync.sv
module hpb_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [1:0] stage;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= {2{RST_VAL[i]}};
      else        stage <= {stage[0], d[i]};
    end
    assign q[i] = stage[1];
  end

endmodule

// File: rtl/hpb_lockout.sv
module hpb_lockout #(
  parameter int unsigned LOCK_CYC = 75000
) (
  input  logic clk,
  input  logic rst_n,
  output logic locked
);

  localparam int unsigned CW = $clog2(LOCK_CYC + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= CW'(LOCK_CYC);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign locked = (remain != '0);

  // R8: once open, the port stays open until the next reset
  p_unlock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> !locked);

endmodule

// File: rtl/hpb_engine.sv
module hpb_engine
  import hpb_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              style_sd,
  input  logic              locked,
  input  logic              s_cs_n,
  input  logic              s_strb_n,
  input  logic              s_rw_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              ack_out,
  output logic              ack_oe
);

  phase_t            phase;
  bus_req_t          req;
  logic              act_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  // named internal events
  logic act_start;
  logic strobe_phase;
  logic ack_phase;

  assign req          = bus_decode(style_sd, s_cs_n, s_strb_n, s_rw_wr);
  assign act_start    = req.act && !act_q && !locked;
  assign strobe_phase = (phase == PH_STROBE);
  assign ack_phase    = (phase == PH_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= req.act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (act_start) begin
            phase   <= PH_STROBE;
            rd_q    <= req.rd;
            addr_q  <= addr;
            wdata_q <= data_in;
          end
        end
        PH_STROBE: begin
          if (rd_q) rdata_q <= reg_rdata;
          phase <= req.act ? PH_ACK : PH_IDLE;
        end
        PH_ACK: begin
          if (!req.act) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_wr    = strobe_phase && !rd_q;
  assign reg_rd    = strobe_phase && rd_q;
  assign data_out  = rdata_q;
  assign data_oe   = ack_phase && rd_q;
  assign ack_oe    = (phase != PH_IDLE);
  assign ack_out   = ack_level(style_sd, phase);

  // R3: a write strobe never lasts more than one cycle
  p_single_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R4: read and write strobes are exclusive
  p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  // R4: the data bus is not driven while a write is strobed
  p_bus_free_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !data_oe);

  // R7: the done phase is always preceded by an internal strobe
  p_ack_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_phase) |-> $past(reg_wr || reg_rd));

  // R8: nothing reaches the registers or the handshake pin while locked
  p_locked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (!reg_wr && !reg_rd && !ack_oe));

endmodule

// File: rtl/dual_bus_host_port.sv
module dual_bus_host_port
  import hpb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 14,
  parameter int unsigned DATA_W  = 16,
  parameter longint unsigned CLK_HZ = 125_000_000,
  parameter int unsigned LOCK_US = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_style,
  input  logic              cs_n,
  input  logic              ds_rd_n,
  input  logic              rw_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              ack_out,
  output logic              ack_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);

  localparam int unsigned LOCK_CYC = lock_cycles(CLK_HZ, LOCK_US);

  logic [2:0] ctl_sync;
  logic       locked;

  hpb_sync #(.WIDTH(3), .RST_VAL(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, ds_rd_n, rw_wr}),
    .q     (ctl_sync)
  );

  hpb_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .locked (locked)
  );

  hpb_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .style_sd  (bus_style),
    .locked    (locked),
    .s_cs_n    (ctl_sync[2]),
    .s_strb_n  (ctl_sync[1]),
    .s_rw_wr   (ctl_sync[0]),
    .addr      (addr),
    .data_in   (data_in),
    .reg_rdata (reg_rdata),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .data_out  (data_out),
    .data_oe   (data_oe),
    .ack_out   (ack_out),
    .ack_oe    (ack_oe)
  );

  // R10: handshake and data drivers are off in the first cycle after reset
  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!ack_oe && !data_oe));

endmodule

// File: tb/dual_bus_host_port_test.sv
module dual_bus_host_port_test;

  localparam longint unsigned CLK_HZ = 125_000_000;
  localparam int unsigned     LOCK_US = 4;
  localparam int unsigned     LOCKN = 500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_style = 1'b1;
  logic        cs_n = 1'b1, ds_rd_n = 1'b1, rw_wr = 1'b1;
  logic [13:0] addr = '0;
  logic [15:0] data_in = '0;
  logic [15:0] data_out, reg_wdata, reg_rdata;
  logic [13:0] reg_addr;
  logic        data_oe, ack_out, ack_oe, reg_wr, reg_rd;

  int checks = 0, errors = 0;
  logic [15:0] regs  [256];
  logic [15:0] model [256];
  int          wr_cnt = 0;
  logic [13:0] last_wa;
  logic [15:0] last_wd;

  always #4 clk = ~clk;

  dual_bus_host_port #(.CLK_HZ(CLK_HZ), .LOCK_US(LOCK_US)) uut (
    .clk(clk), .rst_n(rst_n), .bus_style(bus_style), .cs_n(cs_n),
    .ds_rd_n(ds_rd_n), .rw_wr(rw_wr), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .ack_out(ack_out),
    .ack_oe(ack_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = regs[reg_addr[7:0]];

  always @(posedge clk) begin
    if (reg_wr) begin
      regs[reg_addr[7:0]] <= reg_wdata;
      wr_cnt  <= wr_cnt + 1;
      last_wa <= reg_addr;
      last_wd <= reg_wdata;
    end
  end

  function automatic logic [15:0] seed_val(input int i);
    return 16'(i * 16'h3a7 + 16'h1234);
  endfunction

  // resting and done levels of the handshake pin per style
  function automatic logic rest_lvl(input logic sd);
    return sd;
  endfunction
  function automatic logic done_lvl(input logic sd);
    return !sd;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1; ds_rd_n = 1'b1; rw_wr = 1'b1;
    edges(3);
    chk(!ack_oe && !data_oe && !reg_wr && !reg_rd, "R10", {ack_oe, data_oe, reg_wr, reg_rd}, 0);
    rst_n = 1'b1;
    edges(1);
    chk(!ack_oe && !data_oe, "R10", {ack_oe, data_oe}, 0);
  endtask

  task automatic assert_pins(input logic sd, input logic rd, input logic both);
    cs_n = 1'b0;
    if (sd) begin
      rw_wr = rd; ds_rd_n = 1'b0;
    end else if (both) begin
      ds_rd_n = 1'b0; rw_wr = 1'b0;
    end else if (rd) begin
      ds_rd_n = 1'b0; rw_wr = 1'b1;
    end else begin
      ds_rd_n = 1'b1; rw_wr = 1'b0;
    end
  endtask

  task automatic release_pins();
    cs_n = 1'b1; ds_rd_n = 1'b1; rw_wr = 1'b1;
  endtask

  // Full host access with timing checks. both=1 drives both split strobes.
  task automatic access(input logic sd, input logic rd, input logic both,
                        input logic [13:0] a, input logic [15:0] d, input string req);
    int  w0;
    bit  eff_rd;
    eff_rd = rd || both;
    w0 = wr_cnt;
    @(negedge clk);
    addr = a; data_in = d;
    assert_pins(sd, rd, both);
    edges(2);
    chk(!ack_oe, "R7", ack_oe, 0);
    edges(1);
    chk(ack_oe && ack_out == rest_lvl(sd), sd ? "R5" : "R6", {ack_oe, ack_out}, {1'b1, rest_lvl(sd)});
    edges(1);
    chk(ack_oe && ack_out == done_lvl(sd), sd ? "R5" : "R6", {ack_oe, ack_out}, {1'b1, done_lvl(sd)});
    if (eff_rd) begin
      chk(data_oe && data_out == model[a[7:0]], req, data_out, model[a[7:0]]);
      chk(wr_cnt == w0, both ? "R2" : "R4", wr_cnt - w0, 0);
    end else begin
      model[a[7:0]] = d;
      chk(!data_oe, "R4", data_oe, 0);
      chk(wr_cnt == w0 + 1 && last_wa == a && last_wd == d, "R3",
          last_wd, d);
    end
    release_pins();
    edges(2);
    chk(ack_oe, "R7", ack_oe, 1);
    edges(1);
    chk(!ack_oe && !data_oe && ack_out == rest_lvl(sd), "R7", {ack_oe, data_oe}, 0);
  endtask

  // Access that must be refused: no strobe, no acknowledge.
  task automatic refused(input logic sd, input logic [13:0] a, input string req);
    int w0;
    w0 = wr_cnt;
    @(negedge clk);
    addr = a; data_in = 16'hdead;
    assert_pins(sd, 1'b0, 1'b0);
    edges(6);
    chk(!ack_oe && wr_cnt == w0, req, {ack_oe, 8'(wr_cnt - w0)}, 0);
    release_pins();
    edges(4);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      regs[i]  = seed_val(i);
      model[i] = seed_val(i);
    end
    void'($urandom(32'd5150));

    // ---- strobe-and-direction style ----
    bus_style = 1'b1;
    do_reset();
    refused(1'b1, 14'h0021, "R8");                 // early access during lockout
    // R9: strobe held low across the end of lockout
    @(negedge clk);
    addr = 14'h0022; data_in = 16'hbeef;
    assert_pins(1'b1, 1'b0, 1'b0);
    edges(LOCKN);
    chk(!ack_oe && wr_cnt == 0, "R9", {ack_oe, 8'(wr_cnt)}, 0);
    release_pins();
    edges(4);
    chk(regs[8'h22] == seed_val(8'h22), "R9", regs[8'h22], seed_val(8'h22));

    access(1'b1, 1'b0, 1'b0, 14'h3fff, 16'hffff, "R1");   // top address
    access(1'b1, 1'b1, 1'b0, 14'h3fff, 16'h0,    "R1");
    access(1'b1, 1'b1, 1'b0, 14'h0000, 16'h0,    "R4");
    // R11: strobe without chip select
    @(negedge clk);
    ds_rd_n = 1'b0; rw_wr = 1'b0; addr = 14'h5; data_in = 16'h1;
    edges(6);
    chk(!ack_oe && !reg_wr, "R11", ack_oe, 0);
    release_pins();
    edges(3);

    for (int n = 0; n < 120; n++) begin
      logic [13:0] a;
      logic        rd;
      a  = 14'($urandom);
      rd = 1'($urandom);
      access(1'b1, rd, 1'b0, a, 16'($urandom), "R1");
    end

    // ---- split-strobe style ----
    bus_style = 1'b0;
    do_reset();
    refused(1'b0, 14'h0040, "R8");
    edges(LOCKN);
    access(1'b0, 1'b0, 1'b0, 14'h1234, 16'ha5a5, "R2");
    access(1'b0, 1'b1, 1'b0, 14'h1234, 16'h0,    "R2");
    access(1'b0, 1'b0, 1'b1, 14'h1234, 16'h5a5a, "R2");   // both strobes: read
    @(negedge clk);
    cs_n = 1'b1; rw_wr = 1'b0; addr = 14'h7; data_in = 16'h2;
    edges(6);
    chk(!ack_oe && !reg_wr, "R11", ack_oe, 0);
    release_pins();
    edges(3);

    for (int n = 0; n < 120; n++) begin
      logic [13:0] a;
      logic        rd;
      a  = 14'($urandom);
      rd = 1'($urandom);
      access(1'b0, rd, 1'b0, a, 16'($urandom), "R2");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule